// File: doc/BRIEF.md
# Shared Interrupt Pin Router

This block steers eight shared interrupt link pins onto a vector of sixteen legacy interrupt lines. Each pin has a routing byte. Software writes it through an indexed register port. The byte holds a disable flag and a 4-bit target line number. Several devices may share one pin. Each device pulses an assert strobe when its interrupt rises and a deassert strobe when it falls. The router keeps a count of active sharers for each pin, and the pin is active while that count is nonzero.

An active pin drives its target line only when the routing byte is enabled and names a line from the permitted set. Any other routing value acts as if the pin were disabled. Every output line is the OR of all active pins that are validly routed to it. The output vector is registered. It is computed from the register and count values that take effect at the same clock edge. So a rewrite of an active pin's routing moves the level from the old line to the new line in one edge, with no cycle where both lines or neither line is driven.

Top module: `irq_pin_router`

## Requirements
- R1: Pins are addressed 1 to 8 on `reg_addr`. A write to address 0 or to 9..15 changes no routing byte, and reading such an address returns 0x00.
- R2: A write stores `reg_wdata & 0x8F`. Bit 7 is the disable flag and bits 3:0 are the target line; bits 6:4 always read as zero. `reg_rdata` shows the byte stored at `reg_addr` one clock after the address is presented.
- R3: After reset, every routing byte reads 0x80, every sharer count is zero, `irq_level` is all zeros and `count_err` is 0.
- R4: A pin may drive line n only if bit 7 is 0 and n is in the permitted mask 0xDEF8 (lines 3-7, 9-12, 14, 15). Any other value behaves exactly as if the pin were disabled, so `irq_level` bits 0, 1, 2, 8 and 13 are never set.
- R5: An assert strobe increments a pin's sharer count and a deassert strobe decrements it. Both in the same cycle leave it unchanged. The pin is active while its count is nonzero.
- R6: `irq_level[n]` is the OR over all active pins whose valid routing selects line n, so two pins may drive one line.
- R7: Rewriting an active pin's routing releases the old line and drives the new line at the same clock edge. Writing the value already stored changes nothing.
- R8: The count saturates at 0 on an unmatched deassert and at 7 on an excess assert. Either case sets `count_err`, which stays set until reset.
- R9: `irq_level` is registered. After the edge that samples a write or a strobe, it reflects the new routing and the new count, including when both happen for the same pin in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the routing byte at reg_addr |
| reg_addr | input | 4 | Pin index, 1 to 8 legal |
| reg_wdata | input | 8 | Routing byte to write |
| reg_rdata | output | 8 | Routing byte at reg_addr, registered |
| pin_assert | input | 8 | Per-pin sharer assert strobes, bit p is pin p+1 |
| pin_deassert | input | 8 | Per-pin sharer deassert strobes |
| irq_level | output | 16 | Registered legacy interrupt line levels |
| count_err | output | 1 | Sticky flag for count underflow or overflow |

## Verification
A wrong sharer count shows up at `irq_level` at the edge where the pin should drop or rise. A count that lags by one keeps a line asserted one deassert too long, and this is visible in the next cycle. A bad decode of the routing byte lights a wrong or reserved line as soon as the pin is active. A stale register lags the rewrite by a cycle or leaves the old line held, so the bench compares the full output vector against a reference model after every single edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ROUTE_W       = 8;
  localparam int unsigned DIS_BIT       = 7;
  localparam logic [7:0]  ROUTE_KEEP    = 8'h8F;
  localparam logic [7:0]  ROUTE_AT_RST  = 8'h80;

  function automatic logic route_ok(input logic [7:0] val, input logic [15:0] allowed);
    return !val[DIS_BIT] && allowed[val[3:0]];
  endfunction
endpackage

// File: rtl/irq_route_reg.sv
module irq_route_reg
  import irq_router_pkg::*;
#(
  parameter int unsigned LINES   = 16,
  parameter logic [15:0] ALLOWED = 16'hDEF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         wdata,
  output logic [7:0]         cur_val,
  output logic [LINES-1:0]   nxt_onehot
);
  localparam int unsigned LINE_W = $clog2(LINES);

  logic [7:0] nxt_val;

  always_comb begin
    nxt_val = wr_en ? (wdata & ROUTE_KEEP) : cur_val;
    nxt_onehot = '0;
    if (route_ok(nxt_val, ALLOWED))
      nxt_onehot[nxt_val[LINE_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cur_val <= ROUTE_AT_RST;
    else     cur_val <= nxt_val;
  end

  AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cur_val == ($past(wdata) & ROUTE_KEEP)); // R2
endmodule

// File: rtl/irq_share_count.sv
module irq_share_count #(
  parameter int unsigned CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic nxt_active,
  output logic err_pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt   = cnt;
    err_pulse = 1'b0;
    if (inc && !dec) begin
      if (cnt == CNT_MAX) err_pulse = 1'b1;
      else                cnt_nxt   = cnt + 1'b1;
    end else if (dec && !inc) begin
      if (cnt == '0) err_pulse = 1'b1;
      else           cnt_nxt   = cnt - 1'b1;
    end
    nxt_active = (cnt_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R5
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt == '0) |=> cnt == '0); // R8
  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R8
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
  parameter int unsigned PINS  = 8,
  parameter int unsigned LINES = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PINS-1:0][LINES-1:0]  route_oh,
  input  logic [PINS-1:0]             active,
  output logic [LINES-1:0]            level
);
  logic [LINES-1:0] level_nxt;

  always_comb begin
    level_nxt = '0;
    for (int p = 0; p < PINS; p++)
      if (active[p]) level_nxt = level_nxt | route_oh[p];
  end

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= level_nxt;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |=> level == '0); // R6
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 8,
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned CNT_W     = 3,
  parameter logic [15:0] ALLOWED   = 16'hDEF8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [3:0]            reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  input  logic [NUM_PINS-1:0]   pin_assert,
  input  logic [NUM_PINS-1:0]   pin_deassert,
  output logic [NUM_LINES-1:0]  irq_level,
  output logic                  count_err
);
  localparam int unsigned ADDR_W = 4;

  logic [NUM_PINS-1:0][7:0]           cur_all;
  logic [NUM_PINS-1:0][NUM_LINES-1:0] route_oh;
  logic [NUM_PINS-1:0]                active_nxt;
  logic [NUM_PINS-1:0]                err_vec;
  logic                               addr_ok;

  assign addr_ok = (reg_addr != '0) && (reg_addr <= ADDR_W'(NUM_PINS));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic wr_sel;
    assign wr_sel = reg_wr && (reg_addr == ADDR_W'(p + 1));

    irq_route_reg #(.LINES(NUM_LINES), .ALLOWED(ALLOWED)) u_reg (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_sel),
      .wdata      (reg_wdata),
      .cur_val    (cur_all[p]),
      .nxt_onehot (route_oh[p])
    );

    irq_share_count #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .inc        (pin_assert[p]),
      .dec        (pin_deassert[p]),
      .nxt_active (active_nxt[p]),
      .err_pulse  (err_vec[p])
    );
  end

  irq_line_merge #(.PINS(NUM_PINS), .LINES(NUM_LINES)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .route_oh (route_oh),
    .active   (active_nxt),
    .level    (irq_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      count_err <= 1'b0;
    end else begin
      reg_rdata <= addr_ok ? cur_all[reg_addr - 1'b1] : 8'h00;
      count_err <= count_err | (|err_vec);
    end
  end

  AST_BAD_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !addr_ok) |=> $stable(cur_all)); // R1
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (irq_level & ~ALLOWED) == '0); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    count_err |=> count_err); // R8
endmodule

// File: tb/tb_irq_pin_router.sv
module tb_irq_pin_router;
  localparam logic [15:0] ALLOWED = 16'hDEF8;
  localparam int CMAX = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  pin_assert = '0;
  logic [7:0]  pin_deassert = '0;
  logic [15:0] irq_level;
  logic        count_err;

  always #4 clk = ~clk;

  irq_pin_router dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_assert(pin_assert), .pin_deassert(pin_deassert),
    .irq_level(irq_level), .count_err(count_err)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] m_reg [8];
  int         m_cnt [8];
  logic       m_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_level();
    logic [15:0] v = '0;
    for (int p = 0; p < 8; p++)
      if (m_cnt[p] != 0 && !m_reg[p][7] && ALLOWED[m_reg[p][3:0]])
        v[m_reg[p][3:0]] = 1'b1;
    return v;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 8; p++) begin m_reg[p] = 8'h80; m_cnt[p] = 0; end
    m_err = 1'b0;
  endtask

  // One clock with the given stimulus; output compared right after the edge.
  task automatic step(input string tag, input logic wr, input logic [3:0] a,
                      input logic [7:0] d, input logic [7:0] as, input logic [7:0] ds);
    reg_wr = wr; reg_addr = a; reg_wdata = d; pin_assert = as; pin_deassert = ds;
    @(posedge clk);
    if (wr && a >= 1 && a <= 8) m_reg[a-1] = d & 8'h8F;
    for (int p = 0; p < 8; p++) begin
      if (as[p] && !ds[p]) begin
        if (m_cnt[p] == CMAX) m_err = 1'b1; else m_cnt[p]++;
      end else if (ds[p] && !as[p]) begin
        if (m_cnt[p] == 0) m_err = 1'b1; else m_cnt[p]--;
      end
    end
    #2;
    reg_wr = 1'b0; pin_assert = '0; pin_deassert = '0;
    chk({tag, " level"}, 32'(irq_level), 32'(exp_level()));
    chk({tag, " err"}, 32'(count_err), 32'(m_err));
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    reg_addr = a;
    @(posedge clk); #2;
    chk(tag, 32'(reg_rdata), (a >= 1 && a <= 8) ? 32'(m_reg[a-1]) : 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned lcg = 32'h1234_5678;
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R3: reset state
    chk("R3 level", 32'(irq_level), 32'h0);
    chk("R3 err", 32'(count_err), 32'h0);
    for (int a = 1; a <= 8; a++) rd("R3 reset byte", 4'(a));

    // R1: illegal addresses ignored, read as zero
    step("R1 wr0", 1'b1, 4'd0, 8'h05, '0, '0);
    step("R1 wr9", 1'b1, 4'd9, 8'h05, '0, '0);
    step("R1 wr15", 1'b1, 4'd15, 8'h03, '0, '0);
    for (int a = 0; a < 16; a++) rd("R1 read", 4'(a));

    // R2/R4: write to idle pin does not drive
    step("R4 idle pin", 1'b1, 4'd1, 8'h05, '0, '0);
    // R5: one sharer
    step("R5 assert", 1'b0, 4'd1, 8'h00, 8'h01, '0);
    // R2/R4/R7: sweep all byte values on active pin 1
    for (int v = 0; v < 256; v++) begin
      step("R7 sweep", 1'b1, 4'd1, 8'(v), '0, '0);
      rd("R2 sweep read", 4'd1);
    end
    step("R7 same value", 1'b1, 4'd1, 8'h0F, '0, '0);
    step("R7 to 9", 1'b1, 4'd1, 8'h09, '0, '0);
    step("R7 identical", 1'b1, 4'd1, 8'h09, '0, '0);

    // R5: sharers count up and down
    step("R5 second", 1'b0, 4'd0, 8'h00, 8'h01, '0);
    step("R5 both", 1'b0, 4'd0, 8'h00, 8'h01, 8'h01);
    step("R5 drop one", 1'b0, 4'd0, 8'h00, '0, 8'h01);
    step("R5 drop last", 1'b0, 4'd0, 8'h00, '0, 8'h01);

    // R6: two pins on line 9
    step("R6 pin2 route", 1'b1, 4'd2, 8'h09, 8'h03, '0);
    step("R6 pin1 drop", 1'b0, 4'd0, 8'h00, '0, 8'h01);
    step("R6 pin2 drop", 1'b0, 4'd0, 8'h00, '0, 8'h02);

    // R9: write and strobe to pin 3 in one cycle
    step("R9 wr+assert", 1'b1, 4'd3, 8'h0B, 8'h04, '0);
    step("R9 wr+deassert", 1'b1, 4'd3, 8'h0C, '0, 8'h04);

    // R8: saturation
    step("R8 underflow", 1'b0, 4'd0, 8'h00, '0, 8'h10);
    chk("R8 err set", 32'(count_err), 32'h1);
    for (int i = 0; i < 9; i++) step("R8 overflow", 1'b0, 4'd0, 8'h00, 8'h20, '0);
    step("R8 route 6", 1'b1, 4'd6, 8'h06, '0, '0);
    for (int i = 0; i < 7; i++) step("R8 drain", 1'b0, 4'd0, 8'h00, '0, 8'h20);
    chk("R8 drained", 32'(irq_level), 32'h0);

    // R6/R9 mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      logic       w;
      logic [3:0] a;
      logic [7:0] d, as, ds;
      lcg = lcg * 32'd1103515245 + 32'd12345; w = lcg[20];  a = lcg[27:24];
      lcg = lcg * 32'd1103515245 + 32'd12345; d = lcg[23:16]; as = lcg[31:24] & lcg[15:8];
      lcg = lcg * 32'd1103515245 + 32'd12345; ds = lcg[31:24] & lcg[15:8];
      step("R6 random", w, a, d, as, ds);
    end
    for (int a = 1; a <= 8; a++) rd("R2 final read", 4'(a));

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule